// File: doc/BRIEF.md
# Bit-Manipulation Arithmetic Unit

This block is a purely combinational functional unit that computes one 32-bit result from two register operands (`src_a`, `src_b`), a 5-bit immediate (`imm_val`) and a 5-bit operation code (`op_sel`). It covers the base set of bit-manipulation operations:

- bit counting: leading zeros, trailing zeros and set bits;
- sign extension of the low byte or low halfword;
- signed and unsigned minimum and maximum;
- AND, OR and XOR against the inverted second operand;
- left and right shifts that fill with ones;
- packing of halfwords and bytes;
- scaled add for array indexing.

It sits in the execute stage next to the ordinary ALU. The decoder drives the operation code and the immediate-select flag. The result must be captured by the surrounding pipeline in the same cycle.

One adder serves the compare and scaled-add paths. One inverter on the second operand serves both that adder's subtraction and the inverted-operand logic operations. The shift amount comes from `imm_val` when `use_imm` is high, and otherwise from the low five bits of `src_b`.

Top module: `bmalu_top`

## Requirements
- R1: Op 0 returns the number of consecutive zero bits counted from bit 31 of `src_a`. Op 1 returns the number counted from bit 0.
- R2: Ops 0 and 1 return 32 when `src_a` is zero.
- R3: Op 2 returns the number of set bits in `src_a`.
- R4: Op 3 returns `src_a[7:0]` with bit 7 copied into bits 31:8. Op 4 returns `src_a[15:0]` with bit 15 copied into bits 31:16.
- R5: Op 5 returns the smaller and op 7 the larger of `src_a` and `src_b`, both read as two's complement numbers.
- R6: Op 6 returns the smaller and op 8 the larger of `src_a` and `src_b`, both read as unsigned numbers.
- R7: Ops 9, 10 and 11 return `src_a & ~src_b`, `src_a | ~src_b` and `src_a ^ ~src_b` respectively.
- R8: Op 12 shifts `src_a` left and op 13 shifts it right, each filling the vacated positions with ones. The amount is `imm_val` when `use_imm` is 1, and otherwise `src_b[4:0]`; the upper bits of `src_b` are ignored.
- R9: Op 14 returns `{src_b[15:0], src_a[15:0]}`. Op 15 returns `{src_b[31:16], src_a[31:16]}`.
- R10: Op 16 returns `{16'h0, src_b[7:0], src_a[7:0]}`.
- R11: Ops 17, 18 and 19 return `(src_a << k) + src_b` modulo 2^32, with k equal to 1, 2 and 3 respectively.
- R12: Op codes 20 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| use_imm | input | 1 | Take the shift amount from `imm_val` |
| imm_val | input | 5 | Immediate shift amount |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| result | output | 32 | Operation result |

## Verification
Every operation code is swept over the cross product of the corner operands: zero, all ones, 0x80000000, 1, 0x7FFFFFFF, 0x80 and 0x8000.

- Zero and all ones separate the zero-input count rule from an off-by-one in the counters.
- 0x80000000 against 0x7FFFFFFF is where the signed and unsigned orderings disagree.
- 0x80 and 0x8000 sit exactly on the sign bits of the byte and halfword extensions.

Random operand pairs then cover each operation for carries, packing placement and mixed bit patterns. A full sweep of all 32 immediate amounts, with junk in the upper bits of `src_b`, shows that only the selected five-bit amount steers the ones-fill shifts.

// File: rtl/bmalu_pkg.sv
package bmalu_pkg;
    typedef enum logic [4:0] {
        OP_CLZ    = 5'd0,
        OP_CTZ    = 5'd1,
        OP_CPOP   = 5'd2,
        OP_SEXTB  = 5'd3,
        OP_SEXTH  = 5'd4,
        OP_MIN    = 5'd5,
        OP_MINU   = 5'd6,
        OP_MAX    = 5'd7,
        OP_MAXU   = 5'd8,
        OP_ANDN   = 5'd9,
        OP_ORN    = 5'd10,
        OP_XNOR   = 5'd11,
        OP_SLO    = 5'd12,
        OP_SRO    = 5'd13,
        OP_PACKL  = 5'd14,
        OP_PACKH  = 5'd15,
        OP_PACKB  = 5'd16,
        OP_SHADD1 = 5'd17,
        OP_SHADD2 = 5'd18,
        OP_SHADD3 = 5'd19
    } op_e;
endpackage

// File: rtl/bmalu_count.sv
module bmalu_count #(
    parameter int XLEN = 32,
    localparam int CW = $clog2(XLEN) + 1
) (
    input  logic [XLEN-1:0] val,
    output logic [CW-1:0]   lead_zeros,
    output logic [CW-1:0]   trail_zeros,
    output logic [CW-1:0]   ones
);
    always_comb begin
        logic hit_hi;
        logic hit_lo;
        hit_hi      = 1'b0;
        hit_lo      = 1'b0;
        lead_zeros  = '0;
        trail_zeros = '0;
        ones        = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (!hit_hi && !val[XLEN-1-i]) lead_zeros = lead_zeros + 1'b1;
            else                           hit_hi = 1'b1;
            if (!hit_lo && !val[i])        trail_zeros = trail_zeros + 1'b1;
            else                           hit_lo = 1'b1;
            ones = ones + CW'(val[i]);
        end
    end
endmodule

// File: rtl/bmalu_adder.sv
module bmalu_adder #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic            invert,
    output logic [XLEN-1:0] rhs_inv,
    output logic [XLEN-1:0] sum,
    output logic            carry
);
    assign rhs_inv = rhs ^ {XLEN{invert}};
    assign {carry, sum} = {1'b0, lhs} + {1'b0, rhs_inv} + (XLEN+1)'(invert);
endmodule

// File: rtl/bmalu_shift.sv
module bmalu_shift #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val,
    input  logic [SHW-1:0]  amt,
    output logic [XLEN-1:0] left_ones,
    output logic [XLEN-1:0] right_ones
);
    logic [XLEN-1:0] inv;
    assign inv        = ~val;
    assign left_ones  = ~(inv << amt);
    assign right_ones = ~(inv >> amt);
endmodule

// File: rtl/bmalu_top.sv
module bmalu_top #(
    parameter int XLEN = 32,
    localparam int SHW  = $clog2(XLEN),
    localparam int CW   = SHW + 1,
    localparam int HALF = XLEN / 2
) (
    input  logic [4:0]      op_sel,
    input  logic            use_imm,
    input  logic [SHW-1:0]  imm_val,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] result
);
    import bmalu_pkg::*;

    op_e             op;
    logic [CW-1:0]   n_lead, n_trail, n_ones;
    logic [XLEN-1:0] add_lhs, b_inv, add_sum;
    logic            add_carry, sub_mode;
    logic [SHW-1:0]  sh_amt;
    logic [XLEN-1:0] sl_ones, sr_ones;
    logic            lt_signed, lt_unsigned;

    assign op = op_e'(op_sel);

    bmalu_count #(.XLEN(XLEN)) count_i (
        .val(src_a), .lead_zeros(n_lead), .trail_zeros(n_trail), .ones(n_ones)
    );

    // Subtract for compares and inverted-operand logic; plain add otherwise.
    always_comb begin
        sub_mode = 1'b0;
        add_lhs  = src_a;
        unique case (op)
            OP_MIN, OP_MINU, OP_MAX, OP_MAXU,
            OP_ANDN, OP_ORN, OP_XNOR: sub_mode = 1'b1;
            OP_SHADD1: add_lhs = src_a << 1;
            OP_SHADD2: add_lhs = src_a << 2;
            OP_SHADD3: add_lhs = src_a << 3;
            default: ;
        endcase
    end

    bmalu_adder #(.XLEN(XLEN)) adder_i (
        .lhs(add_lhs), .rhs(src_b), .invert(sub_mode),
        .rhs_inv(b_inv), .sum(add_sum), .carry(add_carry)
    );

    assign lt_unsigned = ~add_carry;
    assign lt_signed   = (src_a[XLEN-1] ^ src_b[XLEN-1]) ? src_a[XLEN-1]
                                                         : add_sum[XLEN-1];

    assign sh_amt = use_imm ? imm_val : src_b[SHW-1:0];

    bmalu_shift #(.XLEN(XLEN)) shift_i (
        .val(src_a), .amt(sh_amt), .left_ones(sl_ones), .right_ones(sr_ones)
    );

    always_comb begin
        result = '0;
        unique case (op)
            OP_CLZ:    result = XLEN'(n_lead);
            OP_CTZ:    result = XLEN'(n_trail);
            OP_CPOP:   result = XLEN'(n_ones);
            OP_SEXTB:  result = {{(XLEN-8){src_a[7]}}, src_a[7:0]};
            OP_SEXTH:  result = {{(XLEN-16){src_a[15]}}, src_a[15:0]};
            OP_MIN:    result = lt_signed   ? src_a : src_b;
            OP_MINU:   result = lt_unsigned ? src_a : src_b;
            OP_MAX:    result = lt_signed   ? src_b : src_a;
            OP_MAXU:   result = lt_unsigned ? src_b : src_a;
            OP_ANDN:   result = src_a & b_inv;
            OP_ORN:    result = src_a | b_inv;
            OP_XNOR:   result = src_a ^ b_inv;
            OP_SLO:    result = sl_ones;
            OP_SRO:    result = sr_ones;
            OP_PACKL:  result = {src_b[HALF-1:0], src_a[HALF-1:0]};
            OP_PACKH:  result = {src_b[XLEN-1:HALF], src_a[XLEN-1:HALF]};
            OP_PACKB:  result = {{(XLEN-16){1'b0}}, src_b[7:0], src_a[7:0]};
            OP_SHADD1, OP_SHADD2, OP_SHADD3: result = add_sum;
            default:   result = '0;
        endcase
    end
endmodule

// File: rtl/bmalu_checker.sv
module bmalu_checker #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input logic [4:0]      op_sel,
    input logic            use_imm,
    input logic [SHW-1:0]  imm_val,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [XLEN-1:0] result
);
    always_comb begin
        if (!$isunknown({op_sel, use_imm, imm_val, src_a, src_b, result})) begin
            if ((op_sel == 5'd0 || op_sel == 5'd1) && src_a == '0)
                a_r2_zero_count: assert (result == XLEN);
            if (op_sel == 5'd2)
                a_r3_pop_bound: assert (result <= XLEN);
            if (op_sel == 5'd6)
                a_r6_minu_order: assert (result <= src_a && result <= src_b &&
                                         (result == src_a || result == src_b));
            if (op_sel == 5'd8)
                a_r6_maxu_order: assert (result >= src_a && result >= src_b &&
                                         (result == src_a || result == src_b));
            if (op_sel == 5'd16)
                a_r10_packb_upper_zero: assert (result[XLEN-1:16] == '0);
            if (op_sel == 5'd12 && (use_imm ? imm_val : src_b[SHW-1:0]) != '0)
                a_r8_slo_fill: assert (result[0] == 1'b1);
            if (op_sel >= 5'd20)
                a_r12_unused_zero: assert (result == '0);
        end
    end
endmodule

bind bmalu_top bmalu_checker #(.XLEN(XLEN)) chk_i (
    .op_sel(op_sel), .use_imm(use_imm), .imm_val(imm_val),
    .src_a(src_a), .src_b(src_b), .result(result)
);

// File: tb/bmalu_top_tb_top.sv
module bmalu_top_tb_top;
    logic        clk = 1'b0;
    logic [4:0]  op_sel = '0;
    logic        use_imm = 1'b0;
    logic [4:0]  imm_val = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] result;
    int          n_run = 0;
    int          n_fail = 0;
    int          cycles = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    bmalu_top dut_i (
        .op_sel(op_sel), .use_imm(use_imm), .imm_val(imm_val),
        .src_a(src_a), .src_b(src_b), .result(result)
    );

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:          return "R1";
            5'd2:                return "R3";
            5'd3, 5'd4:          return "R4";
            5'd5, 5'd7:          return "R5";
            5'd6, 5'd8:          return "R6";
            5'd9, 5'd10, 5'd11:  return "R7";
            5'd12, 5'd13:        return "R8";
            5'd14, 5'd15:        return "R9";
            5'd16:               return "R10";
            5'd17, 5'd18, 5'd19: return "R11";
            default:             return "R12";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [4:0] op, input logic ui,
                                          input logic [4:0] im, input logic [31:0] a,
                                          input logic [31:0] b);
        int          n;
        int          s;
        logic [63:0] w;
        s = ui ? int'(im) : int'(b[4:0]);
        case (op)
            5'd0: begin n = 0; while (n < 32 && a[31-n] == 1'b0) n++; return 32'(n); end
            5'd1: begin n = 0; while (n < 32 && a[n] == 1'b0) n++; return 32'(n); end
            5'd2: begin n = 0; for (int k = 0; k < 32; k++) n += int'(a[k]); return 32'(n); end
            5'd3: return 32'($signed(a[7:0]));
            5'd4: return 32'($signed(a[15:0]));
            5'd5: return ($signed(a) < $signed(b)) ? a : b;
            5'd6: return (a < b) ? a : b;
            5'd7: return ($signed(a) > $signed(b)) ? a : b;
            5'd8: return (a > b) ? a : b;
            5'd9:  return a & ~b;
            5'd10: return a | ~b;
            5'd11: return ~(a ^ b);
            5'd12: begin w = {32'h0, a} << s; return w[31:0] | 32'((64'd1 << s) - 1); end
            5'd13: return (a >> s) | ~(32'hFFFF_FFFF >> s);
            5'd14: return {b[15:0], a[15:0]};
            5'd15: return {b[31:16], a[31:16]};
            5'd16: return {16'h0, b[7:0], a[7:0]};
            5'd17: return 32'(64'(a) * 2 + 64'(b));
            5'd18: return 32'(64'(a) * 4 + 64'(b));
            5'd19: return 32'(64'(a) * 8 + 64'(b));
            default: return 32'h0;
        endcase
    endfunction

    task automatic apply(input logic [4:0] op, input logic ui, input logic [4:0] im,
                         input logic [31:0] a, input logic [31:0] b);
        logic [31:0] exp;
        @(negedge clk);
        op_sel = op; use_imm = ui; imm_val = im; src_a = a; src_b = b;
        exp = model(op, ui, im, a, b);
        @(posedge clk);
        #1;
        n_run++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%0d/%0d actual=%h expected=%h",
                     tag_of(op), op, a, b, ui, im, result, exp);
        end
    endtask

    logic [31:0] corner [7] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1,
                                32'h7FFF_FFFF, 32'h80, 32'h8000};

    initial begin
        // Reset-state style check: all-zero inputs, op 0 (R2).
        apply(5'd0, 1'b0, 5'd0, 32'h0, 32'h0);
        // R2 and R1 directly.
        apply(5'd1, 1'b0, 5'd0, 32'h0, 32'h0);
        apply(5'd0, 1'b0, 5'd0, 32'h0001_0000, 32'h0);
        for (int op = 0; op < 32; op++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    apply(5'(op), 1'b0, 5'd0, corner[i], corner[j]);
        for (int op = 0; op < 32; op++)
            for (int r = 0; r < 150; r++)
                apply(5'(op), 1'($urandom), 5'($urandom), $urandom, $urandom);
        // R8: immediate sweep with junk in src_b upper bits.
        for (int s = 0; s < 32; s++) begin
            apply(5'd12, 1'b1, 5'(s), 32'h1234_5678, 32'hFFFF_FFE0);
            apply(5'd13, 1'b1, 5'(s), 32'h8765_4321, 32'hABCD_EF00);
            apply(5'd12, 1'b0, 5'd7, 32'h0F0F_0F0F, 32'(s) | 32'hA5A5_A500);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule